// File: doc/BRIEF.md
# CRC-32 Barrett Reduction Unit

This block turns a 64-bit polynomial remainder R(x), of degree at most 63, into the 32-bit CRC value R(x) mod P(x) for the generator P(x) = 0x104C11DB7. It does not divide bit by bit. It uses Barrett reduction: a precomputed 33-bit quotient constant u = floor(x^64 / P(x)) = 0x104D101DF, two carry-less multiplies and one XOR.

Each step works on a 32-bit slice. The upper word of R is multiplied by u, and the upper 32 bits of that product estimate the quotient. The estimate is multiplied by P. The low 32 bits of that second product, XORed with the low word of R, give the remainder.

The unit is pipelined and accepts one value per clock. A valid bit travels alongside the data. Producing the 64-bit input, bit reflection and any final inversion happen outside this block.

Top module: `crc32_barrett_reduce`

## Requirements
- R1: With the default configuration, a value accepted with `in_vld` high on a rising edge appears on `out_crc` with `out_vld` high exactly two rising edges later (latency 2).
- R2: While `rst` is high, `out_vld` is held low. After `rst` falls, `out_vld` stays low until the first accepted input emerges.
- R3: `out_crc` equals the remainder of `in_rem` divided by 0x104C11DB7 over GF(2). Bit i of `in_rem` is the coefficient of x^i, so bit 63 is x^63. Bit i of `out_crc` is the coefficient of x^i.
- R4: An input whose upper 32 bits are zero leaves the block unchanged: `out_crc` equals `in_rem[31:0]`.
- R5: Inputs presented on consecutive cycles each produce one result, in input order, on consecutive cycles, with no bubble.
- R6: A cycle with `in_vld` low produces a cycle with `out_vld` low at the output two cycles later. Whatever `in_rem` holds during such a cycle produces no output.
- R7: The result is linear: the CRC of a XOR b equals the CRC of a XOR the CRC of b.
- R8: The single-bit input x^32 (bit 32 set, all other bits clear) reduces to 0x04C11DB7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears the valid bits |
| in_vld | input | 1 | Input value present this cycle |
| in_rem | input | 64 | Polynomial to reduce, bit i is the coefficient of x^i |
| out_vld | output | 1 | Result present this cycle |
| out_crc | output | 32 | Remainder modulo P(x); undefined while `out_vld` is low |

## Verification
The bench targets the following cases and what a faulty design would do in each:
- All-zero input and inputs whose upper word is zero. A design that gets the quotient estimate wrong returns a non-zero correction here.
- The x^32 input and every other single set bit. These expose a dropped or shifted product bit, or a wrong constant.
- The all-ones input. This exposes a truncated product.
- Back-to-back streams and streams with holes carrying garbage data. These catch a pipeline that loses, duplicates or reorders results, or lets idle data through.
- Linearity triples. These confirm the datapath contains no stray state between values.

// File: rtl/crc_barrett_pkg.sv
package crc_barrett_pkg;

   localparam int unsigned CRC_W  = 32;
   localparam int unsigned IN_W   = 2 * CRC_W;
   localparam int unsigned GEN_W  = CRC_W + 1;
   localparam logic [GEN_W-1:0] GEN_POLY  = 33'h1_04C1_1DB7;
   localparam logic [GEN_W-1:0] GEN_QUOT  = 33'h1_04D1_01DF;

   typedef logic [CRC_W-1:0] crc_word_t;
   typedef logic [IN_W-1:0]  rem_word_t;
   typedef logic [GEN_W-1:0] gen_word_t;

   // floor(x^IN_W / poly) by plain long division over GF(2)
   function automatic gen_word_t barrett_quotient(input gen_word_t poly);
      logic [IN_W:0]  work;
      logic [IN_W:0]  pext;
      gen_word_t      q;
      work = '0;
      work[IN_W] = 1'b1;
      q = '0;
      pext = '0;
      pext[GEN_W-1:0] = poly;
      for (int k = IN_W; k >= int'(CRC_W); k--) begin
         if (work[k]) begin
            q[k-CRC_W] = 1'b1;
            work = work ^ (pext << (k - CRC_W));
         end
      end
      return q;
   endfunction

   // remainder by long division, used only by the assertions
   function automatic crc_word_t long_div_rem(input rem_word_t val, input gen_word_t poly);
      rem_word_t work;
      rem_word_t pext;
      work = val;
      pext = '0;
      pext[GEN_W-1:0] = poly;
      for (int k = IN_W - 1; k >= int'(CRC_W); k--) begin
         if (work[k]) work = work ^ (pext << (k - CRC_W));
      end
      return work[CRC_W-1:0];
   endfunction

endpackage

// File: rtl/crc_clmul.sv
module crc_clmul #(
   parameter int unsigned A_W = 32,
   parameter int unsigned B_W = 33,
   localparam int unsigned P_W = A_W + B_W - 1
) (
   input  logic [A_W-1:0] op_a,
   input  logic [B_W-1:0] op_b,
   output logic [P_W-1:0] prod
);

   if (A_W < 1 || B_W < 2) begin : g_bad_width
      $error("crc_clmul: operand widths too small");
   end

   logic [P_W-1:0] b_ext;
   assign b_ext = {{(P_W-B_W){1'b0}}, op_b};

   // each set bit of op_a adds a shifted copy of op_b (XOR, no carries)
   logic [P_W-1:0] partial [A_W+1];
   assign partial[0] = '0;

   for (genvar i = 0; i < int'(A_W); i++) begin : g_row
      assign partial[i+1] = partial[i] ^ (op_a[i] ? (b_ext << i) : '0);
   end

   assign prod = partial[A_W];

endmodule

// File: rtl/crc_pipe_stage.sv
module crc_pipe_stage #(
   parameter int unsigned W   = 32,
   parameter bit          REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         d_vld,
   input  logic [W-1:0] d,
   output logic         q_vld,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_width
      $error("crc_pipe_stage: W must be positive");
   end

   if (REG) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;
      always_ff @(posedge clk) begin
         if (rst) vld_q <= 1'b0;
         else     vld_q <= d_vld;
      end
      // data carries no reset: it is only meaningful under the valid bit
      always_ff @(posedge clk) begin
         if (d_vld) dat_q <= d;
      end
      assign q_vld = vld_q;
      assign q     = dat_q;
   end else begin : g_wire
      assign q_vld = d_vld;
      assign q     = d;
   end

endmodule

// File: rtl/crc32_barrett_reduce.sv
module crc32_barrett_reduce #(
   parameter int unsigned CRC_W     = crc_barrett_pkg::CRC_W,
   parameter logic [CRC_W:0] POLY   = crc_barrett_pkg::GEN_POLY,
   parameter logic [CRC_W:0] QUOT   = crc_barrett_pkg::GEN_QUOT,
   parameter bit          STAGE1_REG = 1'b1,
   localparam int unsigned IN_W  = 2 * CRC_W,
   localparam int unsigned GEN_W = CRC_W + 1,
   localparam int unsigned PR_W  = CRC_W + GEN_W - 1,
   localparam int unsigned LAT   = STAGE1_REG ? 2 : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_vld,
   input  logic [IN_W-1:0]  in_rem,
   output logic             out_vld,
   output logic [CRC_W-1:0] out_crc
);

   if (CRC_W != crc_barrett_pkg::CRC_W) begin : g_bad_crc_w
      $error("crc32_barrett_reduce: CRC_W must match the package width");
   end
   if (!POLY[CRC_W] || !POLY[0]) begin : g_bad_poly
      $error("crc32_barrett_reduce: generator needs top and constant terms");
   end
   if (QUOT != crc_barrett_pkg::barrett_quotient(POLY)) begin : g_bad_quot
      $error("crc32_barrett_reduce: QUOT is not floor(x^2W / POLY)");
   end

   // step 1: quotient estimate from the upper word
   logic [PR_W-1:0] t1_prod;
   crc_clmul #(.A_W(CRC_W), .B_W(GEN_W)) i_mul_quot (
      .op_a (in_rem[IN_W-1:CRC_W]),
      .op_b (QUOT),
      .prod (t1_prod)
   );

   logic              s1_vld;
   logic [IN_W-1:0]   s1_dat;
   crc_pipe_stage #(.W(IN_W), .REG(STAGE1_REG)) i_stage1 (
      .clk   (clk),
      .rst   (rst),
      .d_vld (in_vld),
      .d     ({t1_prod[PR_W-1:PR_W-CRC_W], in_rem[CRC_W-1:0]}),
      .q_vld (s1_vld),
      .q     (s1_dat)
   );

   // step 2: quotient times generator, keep the low word, fold in
   logic [PR_W-1:0] t2_prod;
   crc_clmul #(.A_W(CRC_W), .B_W(GEN_W)) i_mul_poly (
      .op_a (s1_dat[IN_W-1:CRC_W]),
      .op_b (POLY),
      .prod (t2_prod)
   );

   logic [CRC_W-1:0] crc_d;
   assign crc_d = s1_dat[CRC_W-1:0] ^ t2_prod[CRC_W-1:0];

   crc_pipe_stage #(.W(CRC_W), .REG(1'b1)) i_stage2 (
      .clk   (clk),
      .rst   (rst),
      .d_vld (s1_vld),
      .d     (crc_d),
      .q_vld (out_vld),
      .q     (out_crc)
   );

   // cycles since reset, saturating at the latency, for the history checks
   logic [1:0] warm_q;
   always_ff @(posedge clk) begin
      if (rst)                 warm_q <= '0;
      else if (warm_q != 2'(LAT)) warm_q <= warm_q + 2'd1;
   end

   assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
      (warm_q == 2'(LAT)) |-> (out_vld == $past(in_vld, LAT)));

   assert_reset_clears_R2: assert property (@(posedge clk)
      $fell(rst) |-> !out_vld);

   assert_remainder_R3: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (out_crc ==
         crc_barrett_pkg::long_div_rem($past(in_rem, LAT), POLY)));

   assert_low_word_passthru_R4: assert property (@(posedge clk) disable iff (rst)
      (out_vld && ($past(in_rem, LAT) >> CRC_W) == '0) |->
         (out_crc == $past(in_rem[CRC_W-1:0], LAT)));

endmodule

// File: tb/test_crc32_barrett_reduce.sv
`timescale 1ns/1ps
module test_crc32_barrett_reduce;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_vld = 1'b0;
   logic [63:0] in_rem = '0;
   logic        out_vld;
   logic [31:0] out_crc;

   always #4 clk = ~clk;

   crc32_barrett_reduce i_crc32_barrett_reduce (
      .clk     (clk),
      .rst     (rst),
      .in_vld  (in_vld),
      .in_rem  (in_rem),
      .out_vld (out_vld),
      .out_crc (out_crc)
   );

   typedef struct {
      int          cyc;
      logic [31:0] crc;
      string       tag;
   } exp_t;

   exp_t pend[$];
   int   n_chk = 0;
   int   n_fail = 0;
   int   cyc = 0;
   bit   done = 1'b0;

   // shift-in reference: state = state*x + bit mod P, MSB first
   function automatic logic [31:0] ref_crc(input logic [63:0] v);
      logic [31:0] s = '0;
      logic        fb;
      for (int i = 63; i >= 0; i--) begin
         fb = s[31];
         s  = {s[30:0], v[i]};
         if (fb) s = s ^ 32'h04C1_1DB7;
      end
      return s;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // advance to the next falling edge and check what came out
   task automatic step();
      bit due;
      @(negedge clk);
      cyc++;
      due = (pend.size() > 0) && (pend[0].cyc + 2 == cyc);
      chk(due ? "R1 valid timing" : "R6 idle output", 32'(out_vld), 32'(due));
      if (due) begin
         chk(pend[0].tag, out_crc, pend[0].crc);
         void'(pend.pop_front());
      end
   endtask

   task automatic issue(input logic [63:0] v, input logic [31:0] e, input string tag);
      step();
      in_vld = 1'b1;
      in_rem = v;
      pend.push_back('{cyc, e, tag});
   endtask

   task automatic idle(input logic [63:0] junk);
      step();
      in_vld = 1'b0;
      in_rem = junk;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'd20231));
      // R2: valid low throughout reset
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         cyc++;
         chk("R2 reset valid", 32'(out_vld), 32'd0);
      end
      rst = 1'b0;
      idle(64'hDEAD_BEEF_0BAD_F00D);
      idle('0);
      chk("R2 after reset", 32'(out_vld), 32'd0);

      issue(64'd0, 32'd0, "R3 zero");
      issue('1, ref_crc('1), "R3 all ones");
      issue(64'd1 << 32, 32'h04C1_1DB7, "R8 x^32");
      for (int b = 0; b < 64; b++) begin
         if (b < 32) issue(64'd1 << b, 32'd1 << b, "R4 single low bit");
         else        issue(64'd1 << b, ref_crc(64'd1 << b), "R3 single high bit");
      end
      for (int i = 0; i < 200; i++) begin
         logic [31:0] lo = $urandom();
         issue({32'd0, lo}, lo, "R4 low word only");
      end
      // R5: back-to-back random stream
      for (int i = 0; i < 3000; i++) begin
         logic [63:0] v = {$urandom(), $urandom()};
         issue(v, ref_crc(v), "R5 back-to-back");
      end
      // R6: random holes carrying garbage
      for (int i = 0; i < 3000; i++) begin
         logic [63:0] v = {$urandom(), $urandom()};
         if ($urandom_range(0, 2) == 0) idle(v);
         else issue(v, ref_crc(v), "R6 gapped stream");
      end
      // R7: linearity triples
      for (int i = 0; i < 300; i++) begin
         logic [63:0] a = {$urandom(), $urandom()};
         logic [63:0] b = {$urandom(), $urandom()};
         issue(a, ref_crc(a), "R7 operand a");
         issue(b, ref_crc(b), "R7 operand b");
         issue(a ^ b, ref_crc(a) ^ ref_crc(b), "R7 xor of operands");
      end
      for (int i = 0; i < 4; i++) idle('1);
      chk("R5 all results drained", 32'(pend.size()), 32'd0);
      summary();
   end

endmodule